// File: doc/BRIEF.md
# Priority Interrupt Acceptance Unit

This unit sits beside a processor core and decides, cycle by cycle, whether the core should enter an exception handler and which one. It watches seven level-sensitive hardware request lines, one per priority level 1 (lowest) to 7 (highest), and a software trap pulse that carries a 4-bit trap number. The core's 16-bit status word is held here, and its 3-bit priority mask in bits 10:8 gates the hardware lines. When an event is taken, the unit raises a one-cycle accept strobe with the accepted level and the address of the vector entry that the core must fetch.

On entry, the current status word is pushed onto an internal save stack, and the mask is loaded with the accepted level. Traps are taken at level 0, so they leave the mask at 0. A return-from-exception strobe pops the saved word back. Any request that is now above the mask is then taken in the following cycle. The core can also OR bits into the status word or AND them out directly. Setting the mask to 7 shuts out every hardware line, and clearing it to 0 opens them all again.

Top module: `irq_accept_unit`

## Requirements
- R1: During and after synchronous active-low reset, the status word reads 0x0000 and accept is low.
- R2: A hardware line at level L (bit L-1 of the request vector) is accepted only when L is strictly greater than the mask in status bits 10:8. On acceptance, the mask becomes L and accept_level reports L.
- R3: When several eligible hardware lines are active together, the highest level is accepted. The others stay pending and are accepted later, once the mask allows it.
- R4: A higher level that arrives while a lower-level handler runs preempts it. A level equal to or below the current mask is not accepted, even while it is held high.
- R5: A trap pulse with number n is accepted at level 0 whatever the mask is. It sets the mask to 0, so any hardware level can then preempt the trap handler.
- R6: A hardware acceptance at level L reports vector address 0x60 + 4*L. A trap acceptance with number n reports 0x80 + 4*n.
- R7: When a hardware acceptance and a trap pulse meet in the same cycle, the hardware event wins and the trap is kept pending, to be accepted on the next free cycle. A further trap pulse that arrives while one is pending is ignored.
- R8: A return strobe restores the most recently saved status word, mask included. With nothing saved, the return strobe is ignored.
- R9: A set-bits operation ORs the operand into the status word, and a clear-bits operation ANDs the operand into it. OR with 0x0700 blocks all hardware lines, and AND with 0xF8FF reopens them.
- R10: Accept rises in the cycle after the clock edge that sampled the request. No event is accepted at an edge where a return, a set-bits or a clear-bits operation is applied.
- R11: The save stack holds 8 entries. While it is full, no event is accepted until a return frees an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 7 | Hardware request lines, bit L-1 is level L, level-sensitive |
| trap_req | input | 1 | One-cycle software trap pulse |
| trap_num | input | 4 | Trap number carried with trap_req |
| rte_strobe | input | 1 | Return from exception, restores saved status |
| sr_set_en | input | 1 | OR sr_operand into the status word |
| sr_clr_en | input | 1 | AND sr_operand into the status word |
| sr_operand | input | 16 | Operand for the set and clear operations |
| accept | output | 1 | One-cycle strobe, an event was taken |
| accept_level | output | 3 | Level of the taken event, 0 for a trap |
| vector_addr | output | 32 | Vector entry address for the taken event |
| status_word | output | 16 | Current status word, mask in bits 10:8 |

## Verification
The bench builds the unit with its default parameters: seven hardware levels, 4-bit trap numbers and an 8-entry save stack. With these values, one trap followed by all seven levels in rising order fills the stack exactly, so the full-stack hold-off and its release by a single return can both be reached. The 3-bit mask also makes the boundary cases reachable: level 7 held against a mask of 7, and equal-level lines held against their own mask.

// File: rtl/irq_accept_pkg.sv
// Package irq_accept_pkg
// Shared constants and types of the interrupt acceptance unit.
// Assumes a 16-bit status word whose priority mask sits at a fixed offset.
package irq_accept_pkg;
    localparam int SR_W = 16;

    typedef logic [SR_W-1:0] sr_t;

    // Which kind of event is taken at the current edge
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_HW   = 2'd1,
        EV_TRAP = 2'd2
    } ev_kind_t;
endpackage

// File: rtl/irq_prio_select.sv
// Module irq_prio_select
// Picks the highest hardware level whose line is active and whose level is
// strictly above the current mask. Purely combinational.
// Assumes bit i of req stands for level i+1.
module irq_prio_select #(
    parameter int NUM_LEVELS = 7,
    parameter int LVL_W      = 3
) (
    input  logic [NUM_LEVELS-1:0] req,
    input  logic [LVL_W-1:0]      mask,
    output logic                  hit,
    output logic [LVL_W-1:0]      level
);
    logic [NUM_LEVELS-1:0] eligible;

    // Per-level eligibility: line active and level above the mask
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_elig
        localparam logic [LVL_W-1:0] LVL = LVL_W'(i + 1);
        assign eligible[i] = req[i] && (LVL > mask);
    end

    // Highest eligible level wins: scan upward, last hit overrides
    always_comb begin
        hit   = 1'b0;
        level = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (eligible[i]) begin
                hit   = 1'b1;
                level = LVL_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/sr_save_stack.sv
// Module sr_save_stack
// Last-in first-out store of saved status words for nested handlers.
// Assumes the user never pushes when full, never pops when empty, and never
// pushes and pops in the same cycle.
module sr_save_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign top_idx = IDX_W'(count - CNT_W'(1));
    assign wr_idx  = IDX_W'(count);
    assign dout    = mem[top_idx];

    // Occupancy counter: up on push, down on pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + CNT_W'(1);
        end else if (pop && !empty) begin
            count <= count - CNT_W'(1);
        end
    end

    // Entry storage: write the pushed word above the current top
    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wr_idx] <= din;
        end
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    p_push_grows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/irq_accept_unit.sv
// Module irq_accept_unit
// Decides when the core takes an exception. It owns the status word with
// its priority mask, saves and restores the word across nested handlers,
// and reports a one-cycle accept with level and vector address.
// Assumes hardware lines are held until accepted and trap_req is a
// one-cycle pulse issued by the core.
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int              NUM_LEVELS    = 7,
    parameter int              TRAP_NUM_W    = 4,
    parameter int              ADDR_W        = 32,
    parameter int              STACK_DEPTH   = 8,
    parameter int              MASK_LO       = 8,
    parameter logic [ADDR_W-1:0] HW_VEC_BASE   = 'h60,
    parameter logic [ADDR_W-1:0] TRAP_VEC_BASE = 'h80,
    parameter logic [SR_W-1:0]   RESET_SR      = 16'h0000,
    localparam int             LVL_W         = $clog2(NUM_LEVELS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] irq_req,
    input  logic                  trap_req,
    input  logic [TRAP_NUM_W-1:0] trap_num,
    input  logic                  rte_strobe,
    input  logic                  sr_set_en,
    input  logic                  sr_clr_en,
    input  logic [SR_W-1:0]       sr_operand,
    output logic                  accept,
    output logic [LVL_W-1:0]      accept_level,
    output logic [ADDR_W-1:0]     vector_addr,
    output logic [SR_W-1:0]       status_word
);
    sr_t                   sr_q, sr_next;
    logic                  trap_pend_q;
    logic [TRAP_NUM_W-1:0] trap_num_q;
    logic [LVL_W-1:0]      mask;
    logic                  sel_hit;
    logic [LVL_W-1:0]      sel_level;
    logic                  stk_full, stk_empty;
    sr_t                   stk_dout;
    logic                  quiet;
    logic                  trap_any;
    logic [TRAP_NUM_W-1:0] trap_eff;
    ev_kind_t              ev;
    logic                  do_pop;
    logic [ADDR_W-1:0]     hw_vec, trap_vec;

    assign mask = sr_q[MASK_LO +: LVL_W];

    irq_prio_select #(
        .NUM_LEVELS (NUM_LEVELS),
        .LVL_W      (LVL_W)
    ) u_select (
        .req   (irq_req),
        .mask  (mask),
        .hit   (sel_hit),
        .level (sel_level)
    );

    sr_save_stack #(
        .W     (SR_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ev != EV_NONE),
        .pop   (do_pop),
        .din   (sr_q),
        .dout  (stk_dout),
        .full  (stk_full),
        .empty (stk_empty)
    );

    // Event choice: control operations and a full stack hold off acceptance
    always_comb begin
        quiet    = !rte_strobe && !sr_set_en && !sr_clr_en && !stk_full;
        trap_any = trap_pend_q || trap_req;
        trap_eff = trap_pend_q ? trap_num_q : trap_num;
        if (quiet && sel_hit)       ev = EV_HW;
        else if (quiet && trap_any) ev = EV_TRAP;
        else                        ev = EV_NONE;
        do_pop = rte_strobe && !stk_empty;
    end

    // Next status word: return, then set/clear, then event entry
    always_comb begin
        sr_next = sr_q;
        if (do_pop) begin
            sr_next = stk_dout;
        end else if (sr_set_en) begin
            sr_next = sr_q | sr_operand;
        end else if (sr_clr_en) begin
            sr_next = sr_q & sr_operand;
        end else if (ev == EV_HW) begin
            sr_next[MASK_LO +: LVL_W] = sel_level;
        end else if (ev == EV_TRAP) begin
            sr_next[MASK_LO +: LVL_W] = '0;
        end
    end

    // Vector addresses for both event kinds
    assign hw_vec   = HW_VEC_BASE + (ADDR_W'(sel_level) << 2);
    assign trap_vec = TRAP_VEC_BASE + (ADDR_W'(trap_eff) << 2);

    // Status word register
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= RESET_SR;
        else        sr_q <= sr_next;
    end

    // Trap pending latch: hold an untaken trap, ignore pulses while held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_pend_q <= 1'b0;
            trap_num_q  <= '0;
        end else if (ev == EV_TRAP) begin
            trap_pend_q <= 1'b0;
        end else if (trap_req && !trap_pend_q) begin
            trap_pend_q <= 1'b1;
            trap_num_q  <= trap_num;
        end
    end

    // Accept outputs: one-cycle strobe with level and vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept       <= 1'b0;
            accept_level <= '0;
            vector_addr  <= '0;
        end else begin
            accept <= (ev != EV_NONE);
            if (ev == EV_HW) begin
                accept_level <= sel_level;
                vector_addr  <= hw_vec;
            end else if (ev == EV_TRAP) begin
                accept_level <= '0;
                vector_addr  <= trap_vec;
            end
        end
    end

    assign status_word = sr_q;

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (status_word == RESET_SR && !accept));

    p_hw_above_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && accept_level != '0) |-> (accept_level > $past(mask)));

    p_mask_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (status_word[MASK_LO +: LVL_W] == accept_level));

    p_quiet_on_control_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_strobe || sr_set_en || sr_clr_en) |=> !accept);

    p_rte_restores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        do_pop |=> (status_word == $past(stk_dout)));

    p_full_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |=> !accept);
endmodule

// File: tb/irq_accept_unit_tb_top.sv
// Bench irq_accept_unit_tb_top
// Scoreboard bench: the driver pushes the expected accept items into a
// queue, and a monitor pops and compares them whenever accept is seen.
module irq_accept_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  lvl;
        logic [31:0] vec;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  irq_req;
    logic        trap_req;
    logic [3:0]  trap_num;
    logic        rte_strobe;
    logic        sr_set_en;
    logic        sr_clr_en;
    logic [15:0] sr_operand;
    logic        accept;
    logic [2:0]  accept_level;
    logic [31:0] vector_addr;
    logic [15:0] status_word;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_accept_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_req      (irq_req),
        .trap_req     (trap_req),
        .trap_num     (trap_num),
        .rte_strobe   (rte_strobe),
        .sr_set_en    (sr_set_en),
        .sr_clr_en    (sr_clr_en),
        .sr_operand   (sr_operand),
        .accept       (accept),
        .accept_level (accept_level),
        .vector_addr  (vector_addr),
        .status_word  (status_word)
    );

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_acc(input logic [2:0] lvl, input logic [31:0] vec);
        exp_t e;
        e.lvl = lvl;
        e.vec = vec;
        exp_q.push_back(e);
    endtask

    task automatic check_sr(input logic [15:0] want, input string req);
        @(negedge clk);
        n_checks++;
        if (status_word !== want) begin
            n_fail++;
            $display("FAIL %s status_word actual=%h expected=%h", req, status_word, want);
        end
    endtask

    task automatic do_rte();
        rte_strobe = 1'b1;
        tick();
        rte_strobe = 1'b0;
    endtask

    task automatic do_set(input logic [15:0] op);
        sr_set_en = 1'b1; sr_operand = op;
        tick();
        sr_set_en = 1'b0;
    endtask

    task automatic do_clr(input logic [15:0] op);
        sr_clr_en = 1'b1; sr_operand = op;
        tick();
        sr_clr_en = 1'b0;
    endtask

    task automatic do_trap(input logic [3:0] num);
        trap_req = 1'b1; trap_num = num;
        tick();
        trap_req = 1'b0;
    endtask

    // Monitor: compare every accept against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1 && accept === 1'b1) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4/R10 unexpected accept actual level=%0d vec=%h expected none",
                         accept_level, vector_addr);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (accept_level !== e.lvl || vector_addr !== e.vec) begin
                    n_fail++;
                    $display("FAIL R6 accept actual level=%0d vec=%h expected level=%0d vec=%h",
                             accept_level, vector_addr, e.lvl, e.vec);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Driver
    initial begin
        rst_n = 1'b0; irq_req = '0; trap_req = 1'b0; trap_num = '0;
        rte_strobe = 1'b0; sr_set_en = 1'b0; sr_clr_en = 1'b0; sr_operand = '0;
        tick(3);
        // R1: reset state
        @(negedge clk);
        n_checks++;
        if (status_word !== 16'h0000 || accept !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset actual sr=%h acc=%b expected sr=0000 acc=0",
                     status_word, accept);
        end
        tick();
        rst_n = 1'b1;
        tick();

        // R2/R4: level 3 taken once while held, mask becomes 3
        irq_req[2] = 1'b1; expect_acc(3'd3, 32'h6C);
        tick(3);
        check_sr(16'h0300, "R2");
        irq_req[2] = 1'b0;

        // R4: level 2 below mask stays pending
        irq_req[1] = 1'b1;
        tick(3);
        check_sr(16'h0300, "R4");

        // R3: 5 and 6 together, 6 wins
        irq_req[4] = 1'b1; irq_req[5] = 1'b1; expect_acc(3'd6, 32'h78);
        tick();
        irq_req[5] = 1'b0;
        tick(2);
        check_sr(16'h0600, "R3");

        // R8/R3: return lets pending 5 through
        expect_acc(3'd5, 32'h74);
        do_rte();
        tick();
        irq_req[4] = 1'b0;
        tick(2);
        check_sr(16'h0500, "R8");

        // R8: return to mask 3, then to 0 where level 2 gets in
        do_rte();
        check_sr(16'h0300, "R8");
        expect_acc(3'd2, 32'h68);
        do_rte();
        tick();
        irq_req[1] = 1'b0;
        tick(2);
        check_sr(16'h0200, "R8");
        do_rte();
        check_sr(16'h0000, "R8");

        // R9: set mask 7, level 7 blocked
        do_set(16'h0700);
        irq_req[6] = 1'b1;
        tick(3);
        check_sr(16'h0700, "R9");
        // R8: return with empty stack ignored
        do_rte();
        tick();
        check_sr(16'h0700, "R8");
        // R9/R10: clear mask, level 7 enters one edge later
        expect_acc(3'd7, 32'h7C);
        do_clr(16'hF8FF);
        tick();
        irq_req[6] = 1'b0;
        tick();
        check_sr(16'h0700, "R9");
        do_set(16'h0001);
        check_sr(16'h0701, "R9");
        do_clr(16'hFFFE);
        check_sr(16'h0700, "R9");
        do_rte();
        check_sr(16'h0000, "R8");

        // R5: trap ignores mask 7 and sets mask 0
        do_set(16'h0700);
        expect_acc(3'd0, 32'hBC);
        do_trap(4'd15);
        tick();
        check_sr(16'h0000, "R5");
        // R5: level 1 preempts the trap handler
        irq_req[0] = 1'b1; expect_acc(3'd1, 32'h64);
        tick();
        irq_req[0] = 1'b0;
        tick();
        check_sr(16'h0100, "R5");
        do_rte();
        do_rte();
        check_sr(16'h0700, "R8");
        do_clr(16'hF8FF);
        check_sr(16'h0000, "R9");

        // R7: hardware 4 and trap 2 together; a trap 9 pulse while pending is ignored
        expect_acc(3'd4, 32'h70);
        expect_acc(3'd0, 32'h88);
        irq_req[3] = 1'b1; trap_req = 1'b1; trap_num = 4'd2;
        tick();
        irq_req[3] = 1'b0; trap_num = 4'd9;
        tick();
        trap_req = 1'b0;
        tick(3);
        check_sr(16'h0000, "R7");
        do_rte();
        check_sr(16'h0400, "R7");
        do_rte();
        check_sr(16'h0000, "R7");

        // R11: fill the stack with a trap and all seven levels
        expect_acc(3'd0, 32'h80);
        do_trap(4'd0);
        tick();
        for (int l = 1; l <= 7; l++) begin
            irq_req[l-1] = 1'b1;
            expect_acc(3'(l), 32'h60 + 32'(4 * l));
            tick();
            irq_req = '0;
            tick();
        end
        check_sr(16'h0700, "R11");
        do_trap(4'd3);
        tick(3);
        check_sr(16'h0700, "R11");
        expect_acc(3'd0, 32'h8C);
        do_rte();
        tick(2);
        check_sr(16'h0000, "R11");
        for (int k = 0; k < 8; k++) do_rte();
        check_sr(16'h0000, "R8");

        tick(3);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 missing accepts actual pending=%0d expected 0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule